// File: doc/BRIEF.md
# Shared-Prescaler Tick Generator

This block produces clock-enable ticks for a group of timer channels. One programmable 8-bit prescaler counts peripheral clocks and emits a one-cycle pulse every `presc_i + 1` cycles. Every channel in the group sees that pulse.

Each channel has its own 4-bit divider stage clocked by that pulse. A per-channel 3-bit select field picks the channel's tick source: the prescaler pulse divided by 2, 4, 8 or 16, or a shared external clock. The external clock is first synchronized and then edge-detected.

All outputs are single-cycle enables in the peripheral clock domain. The timer channels that consume them, and the register decode that drives the inputs, sit outside this block.

The external-clock edge detector is a two-state machine:
- `EXT_WAIT_HIGH`: the synchronized level is low. The transition *arm → fire*, taken when the level is seen high, emits one rise pulse and moves to `EXT_WAIT_LOW`.
- `EXT_WAIT_LOW`: the state holds until the synchronized level is low again. The transition *fire → rearm* then returns to `EXT_WAIT_HIGH`.

Top module: `pwm_tick_gen`

## Requirements
- R1: While reset is asserted every bit of `tick_o` is 0.
- R2: The prescaler pulses once every P+1 clocks, where P is the value it latched. A channel with select 0 therefore ticks every 2·(P+1) clocks, for P from 0 up to 255.
- R3: Select codes choose the division of the prescaler pulse: code 0 gives ÷2, code 1 gives ÷4, code 2 gives ÷8 and code 3 gives ÷16. The tick interval is (P+1)·2^(code+1) clocks.
- R4: Select code 4 gives one tick per rising edge of `ext_clk_i`. If `ext_clk_i` rises during clock cycle c, the tick is high during cycle c+3 and stays low for the rest of the high phase.
- R5: Select codes 5, 6 and 7 behave exactly as code 4.
- R6: A new prescale value is adopted only when the prescaler wraps. Example: the value changes from 9 to 3 in the cycle right after a select-0 tick. The next tick comes 14 clocks later (10 + 4), and ticks then come every 8 clocks.
- R7: No channel's tick is high in two consecutive cycles.
- R8: Changing one channel's select field does not alter the tick timing of any other channel.
- R9: With a divided-clock select (codes 0 to 3), activity on `ext_clk_i` has no effect on that channel's ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_i | input | PRE_W | Prescale value P (period P+1) |
| src_sel_i | input | NUM_CH*3 | Per-channel source select; channel k uses bits [3k+2:3k] |
| ext_clk_i | input | 1 | External tick clock, asynchronous |
| tick_o | output | NUM_CH | One-cycle tick enable per channel |

## Verification
The bench builds the block with NUM_CH=3 and PRE_W=8. Three channels let one channel be measured while the select fields of the other two are rewritten. The full 8-bit prescale range brings both the shortest period (P=0 with ÷2, 2 clocks) and the longest (P=255 with ÷16, 4096 clocks) within a short run. A free-running external clock with a 14-cycle period stays active during every divided-clock measurement, so any leakage of external edges into those channels shows up as a wrong interval.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    localparam int unsigned SEL_W = 3;
    localparam int unsigned DIV_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_DIV2  = 3'd0,
        SRC_DIV4  = 3'd1,
        SRC_DIV8  = 3'd2,
        SRC_DIV16 = 3'd3,
        SRC_EXT   = 3'd4
    } tick_src_e;

    typedef enum logic [0:0] {
        EXT_WAIT_HIGH = 1'b0,
        EXT_WAIT_LOW  = 1'b1
    } ext_state_e;

endpackage

// File: rtl/pwm_tick_prescale.sv
module pwm_tick_prescale #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PRE_W-1:0] presc_i,
    output logic             pre_tick_o,
    output logic [PRE_W-1:0] limit_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit_q;
    logic             wrap;

    assign wrap       = (cnt_q == limit_q);
    assign pre_tick_o = wrap;
    assign limit_o    = limit_q;

    // The limit is only re-latched on wrap, so a running period finishes.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else if (wrap) begin
            cnt_q   <= '0;
            limit_q <= presc_i;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_tick_ext_edge.sv
module pwm_tick_ext_edge
    import pwm_tick_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_clk_i,
    output logic rise_o
);

    logic       sync1_q;
    logic       sync2_q;
    ext_state_e state_q;
    ext_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ext_clk_i;
            sync2_q <= sync1_q;
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= EXT_WAIT_HIGH;
        else         state_q <= state_d;
    end

    // Next state and rise pulse.
    always_comb begin
        state_d = state_q;
        rise_o  = 1'b0;
        unique case (state_q)
            EXT_WAIT_HIGH: begin
                if (sync2_q) begin
                    state_d = EXT_WAIT_LOW;
                    rise_o  = 1'b1;
                end
            end
            EXT_WAIT_LOW: begin
                if (!sync2_q) state_d = EXT_WAIT_HIGH;
            end
            default: state_d = EXT_WAIT_HIGH;
        endcase
    end

endmodule

// File: rtl/pwm_tick_chan.sv
module pwm_tick_chan
    import pwm_tick_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pre_tick_i,
    input  logic             ext_rise_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] div_q;
    logic             hit;
    logic             tick_q;
    tick_src_e        src;

    assign src    = tick_src_e'(sel_i);
    assign tick_o = tick_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         div_q <= '0;
        else if (pre_tick_i) div_q <= div_q + 1'b1;
    end

    // Codes above SRC_EXT fall to the default arm and act as external.
    always_comb begin
        hit = 1'b0;
        unique case (src)
            SRC_DIV2:  hit = pre_tick_i &   div_q[0];
            SRC_DIV4:  hit = pre_tick_i & (&div_q[1:0]);
            SRC_DIV8:  hit = pre_tick_i & (&div_q[2:0]);
            SRC_DIV16: hit = pre_tick_i & (&div_q[3:0]);
            default:   hit = ext_rise_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= hit;
    end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_tick_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned PRE_W  = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [PRE_W-1:0]        presc_i,
    input  logic [NUM_CH*SEL_W-1:0] src_sel_i,
    input  logic                    ext_clk_i,
    output logic [NUM_CH-1:0]       tick_o
);

    logic             pre_tick;
    logic [PRE_W-1:0] pre_limit;
    logic             ext_rise;

    pwm_tick_prescale #(.PRE_W(PRE_W)) presc_u (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .presc_i    (presc_i),
        .pre_tick_o (pre_tick),
        .limit_o    (pre_limit)
    );

    pwm_tick_ext_edge ext_u (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ext_clk_i (ext_clk_i),
        .rise_o    (ext_rise)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pwm_tick_chan chan_u (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .pre_tick_i (pre_tick),
            .ext_rise_i (ext_rise),
            .sel_i      (src_sel_i[k*SEL_W +: SEL_W]),
            .tick_o     (tick_o[k])
        );
    end

endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk
    import pwm_tick_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned PRE_W  = 8
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [PRE_W-1:0]        presc_i,
    input logic [NUM_CH*SEL_W-1:0] src_sel_i,
    input logic [NUM_CH-1:0]       tick_o,
    input logic                    pre_tick_i,
    input logic [PRE_W-1:0]        limit_i,
    input logic                    ext_rise_i
);

    // R2: the prescaler adopts the value present at its wrap.
    a_r2_limit_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_tick_i |=> (limit_i == $past(presc_i)));

    // R6: between wraps the active prescale value is frozen.
    a_r6_limit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pre_tick_i |=> $stable(limit_i));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        // R7: ticks last one cycle.
        a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tick_o[k] |=> !tick_o[k]);

        // R3: a divided tick always follows a prescaler pulse.
        a_r3_follows_prescaler: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_o[k] && ($past(src_sel_i[k*SEL_W +: SEL_W]) < SEL_W'(DIV_W)))
            |-> $past(pre_tick_i));

        // R4/R5: an external-source tick always follows a detected rise.
        a_r4_follows_ext_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_o[k] && ($past(src_sel_i[k*SEL_W +: SEL_W]) >= SEL_W'(DIV_W)))
            |-> $past(ext_rise_i));
    end

endmodule

bind pwm_tick_gen pwm_tick_gen_chk #(.NUM_CH(NUM_CH), .PRE_W(PRE_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .presc_i    (presc_i),
    .src_sel_i  (src_sel_i),
    .tick_o     (tick_o),
    .pre_tick_i (pre_tick),
    .limit_i    (pre_limit),
    .ext_rise_i (ext_rise)
);

// File: tb/pwm_tick_gen_tb_top.sv
module pwm_tick_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;
    localparam int EXT_HALF   = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   presc = '0;
    logic [2:0]   sel_arr [NCH];
    logic [NCH*3-1:0] src_sel;
    logic         ext_run = 1'b1;
    logic         ext_gen = 1'b0;
    logic         ext_man = 1'b0;
    logic         ext_clk;
    logic [NCH-1:0] tick;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    int    exp_q [$];
    bit    mon_en = 1'b0;
    int    mon_ch = 0;
    bit    have_last = 1'b0;
    int    last_cyc = 0;
    string mon_req = "";

    assign src_sel = {sel_arr[2], sel_arr[1], sel_arr[0]};
    assign ext_clk = ext_run ? ext_gen : ext_man;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_tick_gen #(.NUM_CH(NCH), .PRE_W(8)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .presc_i   (presc),
        .src_sel_i (src_sel),
        .ext_clk_i (ext_clk),
        .tick_o    (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Free-running external clock, period 2*EXT_HALF cycles.
    initial begin
        forever begin
            repeat (EXT_HALF) @(negedge clk);
            ext_gen = ~ext_gen;
        end
    end

    // Monitor: pops one expected interval per observed tick.
    always @(negedge clk) begin
        if (mon_en && rst_n && tick[mon_ch]) begin
            if (have_last && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                check((cyc - last_cyc) == e, mon_req, cyc - last_cyc, e);
            end
            have_last = 1'b1;
            last_cyc  = cyc;
        end
    end

    // Driver: let the channel settle, then push n expected intervals.
    task automatic expect_period(input int ch, input int per, input int n, input string req);
        mon_en    = 1'b0;
        have_last = 1'b0;
        mon_ch    = ch;
        mon_req   = req;
        repeat (2) @(negedge clk iff tick[ch]);
        #1;
        for (int i = 0; i < n; i++) exp_q.push_back(per);
        mon_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) sel_arr[i] = 3'd0;
        // R1: outputs idle during reset
        repeat (4) @(negedge clk);
        for (int i = 0; i < NCH; i++) check(tick[i] == 1'b0, "R1", tick[i], 0);
        rst_n = 1'b1;

        // R2: P=0, /2 -> 2 clocks (shortest period)
        presc = 8'd0; sel_arr[0] = 3'd0;
        expect_period(0, 2, 3, "R2");

        // R3 (and R9: external clock toggles throughout)
        presc = 8'd4;
        sel_arr[0] = 3'd0; sel_arr[1] = 3'd1; sel_arr[2] = 3'd2;
        expect_period(0, 10, 2, "R3");
        expect_period(1, 20, 2, "R3");
        expect_period(2, 40, 2, "R3");
        presc = 8'd1; sel_arr[0] = 3'd3;
        expect_period(0, 32, 2, "R9");

        // R2: P=255, /16 -> 4096 clocks (longest period)
        presc = 8'd255; sel_arr[2] = 3'd3;
        expect_period(2, 4096, 2, "R2");

        // R4/R5: external select and its aliases
        presc = 8'd4;
        sel_arr[1] = 3'd4;
        expect_period(1, 2*EXT_HALF, 2, "R4");
        sel_arr[1] = 3'd6;
        expect_period(1, 2*EXT_HALF, 2, "R5");
        sel_arr[0] = 3'd7; sel_arr[2] = 3'd5;
        expect_period(0, 2*EXT_HALF, 2, "R5");
        expect_period(2, 2*EXT_HALF, 1, "R5");

        // R8: other channels' selects change while channel 0 is measured
        presc = 8'd2; sel_arr[0] = 3'd3;
        fork
            expect_period(0, 48, 3, "R8");
            begin
                for (int i = 0; i < 12; i++) begin
                    repeat (11) @(negedge clk);
                    sel_arr[1] = 3'(i % 8);
                    sel_arr[2] = 3'((i + 3) % 8);
                end
            end
        join

        // R6: prescale change right after a tick keeps the running period
        presc = 8'd9; sel_arr[0] = 3'd0;
        repeat (3) @(negedge clk iff tick[0]);
        @(negedge clk iff tick[0]);
        #1;
        presc     = 8'd3;
        mon_ch    = 0;
        mon_req   = "R6";
        have_last = 1'b1;
        last_cyc  = cyc;
        exp_q.push_back(14);
        exp_q.push_back(8);
        exp_q.push_back(8);
        mon_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        mon_en = 1'b0;

        // R4: latency from a rise of the external clock, one tick per edge
        ext_man = 1'b0; ext_run = 1'b0; sel_arr[2] = 3'd4;
        repeat (10) @(negedge clk);
        begin
            int c0;
            int first;
            int cnt;
            @(negedge clk);
            ext_man = 1'b1;
            c0 = cyc; first = -1; cnt = 0;
            repeat (12) begin
                @(negedge clk);
                if (tick[2]) begin
                    cnt++;
                    if (first < 0) first = cyc;
                end
            end
            check((first - c0) == 3, "R4", first - c0, 3);
            check(cnt == 1, "R4", cnt, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule